// File: doc/BRIEF.md
# Instinct Rule Action Selector

This block chooses which motor action a mobile platform performs. It ranks a set of per-action strength scores that come from a learned mapping. While no behaviour rule is broken, it simply follows the strongest score. When a rule violation is flagged, it starts a trial. In a trial it steps through the remaining actions in falling order of strength and judges each one by "tension", an unweighted sum of every sensor reading.

At the start of each trial the current tension is latched. A trial succeeds if the violation clears, or if tension falls below the latched value by more than a programmable threshold. On success the block emits a one-cycle training strobe that names the winning action. A trial is dropped early if tension climbs by more than the threshold. It is also dropped if its period runs out while tension stays flat. Either way the next untried action takes over. Once every action has been tried without relief, the trial period doubles, up to a ceiling, and the search starts again from the strongest action.

Top module: `action_selector`

## Requirements
- R1: With no trial under way, `action` is the index of the highest strength in the same cycle, where `strength` holds action i in bits [8i+7:8i]; a tie goes to the lower index.
- R2: A violation seen at a clock edge while idle starts a trial at that edge. The trial uses the strongest action other than the current idle choice.
- R3: A trial succeeds at an edge where `violation` is low. On success `train_valid` is high for the next cycle and `train_action` names the action of the trial. The block then returns to idle.
- R4: Tension is the plain sum of the 8-bit sensor channels, where channel j is in bits [8j+7:8j]. A trial also succeeds when the latched tension minus the current tension is strictly greater than `threshold`; a fall equal to the threshold has no effect.
- R5: A rise in tension strictly greater than `threshold` ends the trial at that edge. The strongest untried action takes over, and tension is latched again.
- R6: A trial that sees neither success nor a significant rise holds its action for exactly `trial_len` cycles. The strongest untried action then takes over.
- R7: When a trial ends with every action tried, `trial_len` doubles, capped at MAX_LEN, and the strongest action is tried again with the new period.
- R8: A successful trial returns `trial_len` to BASE_LEN.
- R9: After reset the block is idle, `train_valid` is low and `trial_len` equals BASE_LEN.
- R10: `train_valid` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strength | input | N_ACT*SW | Packed per-action strength scores |
| violation | input | 1 | Behaviour rule currently broken |
| sensors | input | N_SENS*SENW | Packed sensor readings |
| threshold | input | TW | Minimum tension change treated as significant |
| action | output | AW | Action currently driven to the motors |
| train_valid | output | 1 | One-cycle strobe for a successful trial |
| train_action | output | AW | Action to use as the training target |
| trial_len | output | DW | Current trial period in cycles |

## Verification
In idle, `action` follows the strengths in the same cycle. A trial's action appears one edge after the violation is seen. The training strobe appears one edge after the success condition is met, and it lasts exactly one cycle. A trial that times out shows its action for `trial_len - 1` sampled cycles after the edge that started it. The replacement action shows on the sample after that. The driver changes inputs just after a rising edge and queues the values expected once those inputs have settled. The monitor compares them at the following falling edge, so every expected value is pinned to the count of edges that have passed since the stimulus.

// File: rtl/action_selector.sv
module action_selector #(
  parameter int N_ACT    = 4,
  parameter int SW       = 8,
  parameter int N_SENS   = 4,
  parameter int SENW     = 8,
  parameter int DW       = 8,
  parameter int BASE_LEN = 4,
  parameter int MAX_LEN  = 64,
  localparam int AW = $clog2(N_ACT),
  localparam int TW = SENW + $clog2(N_SENS) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_ACT*SW-1:0]    strength,
  input  logic                   violation,
  input  logic [N_SENS*SENW-1:0] sensors,
  input  logic [TW-1:0]          threshold,
  output logic [AW-1:0]          action,
  output logic                   train_valid,
  output logic [AW-1:0]          train_action,
  output logic [DW-1:0]          trial_len
);

  function automatic logic [AW-1:0] pick(input logic [N_ACT*SW-1:0] s,
                                         input logic [N_ACT-1:0] m);
    logic [AW-1:0] idx;
    logic [SW-1:0] best;
    logic          found;
    idx = '0;
    best = '0;
    found = 1'b0;
    for (int i = 0; i < N_ACT; i++) begin
      if (!m[i] && (!found || s[i*SW +: SW] > best)) begin
        idx = AW'(i);
        best = s[i*SW +: SW];
        found = 1'b1;
      end
    end
    return idx;
  endfunction

  function automatic logic [N_ACT-1:0] bit_of(input logic [AW-1:0] a);
    return N_ACT'(1) << a;
  endfunction

  logic              in_trial;
  logic [AW-1:0]     act_q;
  logic [N_ACT-1:0]  tried;
  logic [TW-1:0]     base_t;
  logic [TW-1:0]     tension;
  logic [DW-1:0]     timer;
  logic [DW-1:0]     dur;

  always_comb begin
    tension = '0;
    for (int j = 0; j < N_SENS; j++)
      tension = tension + TW'(sensors[j*SENW +: SENW]);
  end

  wire [AW-1:0] top_all = pick(strength, '0);
  wire [AW-1:0] runner  = pick(strength, bit_of(top_all));
  wire [AW-1:0] next_un = pick(strength, tried);

  wire fall = (base_t > tension) && ((base_t - tension) > threshold);
  wire rise = (tension > base_t) && ((tension - base_t) > threshold);
  wire all_tried = &tried;

  wire [DW:0]   dbl    = {dur, 1'b0};
  wire [DW-1:0] dur_up = (dbl > (DW+1)'(MAX_LEN)) ? DW'(MAX_LEN) : dbl[DW-1:0];

  assign action    = in_trial ? act_q : top_all;
  assign trial_len = dur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_trial     <= 1'b0;
      act_q        <= '0;
      tried        <= '0;
      base_t       <= '0;
      timer        <= '0;
      dur          <= DW'(BASE_LEN);
      train_valid  <= 1'b0;
      train_action <= '0;
    end else begin
      train_valid <= 1'b0;
      if (!in_trial) begin
        if (violation) begin
          in_trial <= 1'b1;
          act_q    <= runner;
          tried    <= bit_of(top_all) | bit_of(runner);
          base_t   <= tension;
          timer    <= dur - 1'b1;
        end
      end else if (!violation || fall) begin
        in_trial     <= 1'b0;
        train_valid  <= 1'b1;
        train_action <= act_q;
        dur          <= DW'(BASE_LEN);
      end else if (rise || timer == '0) begin
        base_t <= tension;
        if (all_tried) begin
          act_q <= top_all;
          tried <= bit_of(top_all);
          dur   <= dur_up;
          timer <= dur_up - 1'b1;
        end else begin
          act_q <= next_un;
          tried <= tried | bit_of(next_un);
          timer <= dur - 1'b1;
        end
      end else begin
        timer <= timer - 1'b1;
      end
    end
  end

endmodule

// File: rtl/action_selector_chk.sv
module action_selector_chk #(
  parameter int AW       = 2,
  parameter int DW       = 8,
  parameter int BASE_LEN = 4,
  parameter int MAX_LEN  = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_trial,
  input logic [AW-1:0] action,
  input logic          train_valid,
  input logic [AW-1:0] train_action,
  input logic [DW-1:0] trial_len
);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    train_valid |=> !train_valid);

  assert_target_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    train_valid |-> train_action == $past(action));

  assert_trial_switches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_trial) |-> action != $past(action));

  assert_len_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_len != $past(trial_len)) |->
      (trial_len == DW'(BASE_LEN) || trial_len == DW'(MAX_LEN) ||
       {1'b0, trial_len} == {$past(trial_len), 1'b0}));

  assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trial_len <= DW'(MAX_LEN));

  assert_len_restored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_valid) |-> trial_len == DW'(BASE_LEN));

endmodule

bind action_selector action_selector_chk #(
  .AW(AW), .DW(DW), .BASE_LEN(BASE_LEN), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_trial(in_trial), .action(action),
  .train_valid(train_valid), .train_action(train_action), .trial_len(trial_len)
);

// File: tb/action_selector_test.sv
`timescale 1ns/1ps
module action_selector_test;

  localparam int BASE = 2;
  localparam int MAXL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] strength = '0;
  logic        violation = 1'b0;
  logic [31:0] sensors = '0;
  logic [10:0] threshold = 11'd20;
  logic [1:0]  action;
  logic        train_valid;
  logic [1:0]  train_action;
  logic [7:0]  trial_len;

  always #2.5 clk = ~clk;

  action_selector #(
    .N_ACT(4), .SW(8), .N_SENS(4), .SENW(8), .DW(8),
    .BASE_LEN(BASE), .MAX_LEN(MAXL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .strength(strength), .violation(violation),
    .sensors(sensors), .threshold(threshold), .action(action),
    .train_valid(train_valid), .train_action(train_action), .trial_len(trial_len)
  );

  typedef struct {
    string      req;
    logic [1:0] act;
    logic       tv;
    logic [1:0] ta;
    logic [7:0] len;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic expect_out(string req, int act, bit tv, int ta, int len);
    exp_t e;
    e.req = req; e.act = 2'(act); e.tv = tv; e.ta = 2'(ta); e.len = 8'(len);
    q.push_back(e);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_sens(int a, int b, int c, int d);
    sensors = {8'(d), 8'(c), 8'(b), 8'(a)};
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (action !== e.act || train_valid !== e.tv || trial_len !== e.len ||
          (e.tv && train_action !== e.ta)) begin
        errors++;
        $display("FAIL %s: action=%0d tv=%0b ta=%0d len=%0d expected action=%0d tv=%0b ta=%0d len=%0d",
                 e.req, action, train_valid, train_action, trial_len,
                 e.act, e.tv, e.ta, e.len);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int order[4] = '{1, 3, 2, 0};

  initial begin
    int d;
    strength = {8'd50, 8'd30, 8'd50, 8'd10};
    set_sens(25, 25, 25, 25);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_out("R9", 1, 0, 0, BASE);
    step();
    // R1: idle ranking follows the strengths in the same cycle
    strength = {8'd5, 8'd5, 8'd5, 8'd5};
    #1 expect_out("R1", 0, 0, 0, BASE);
    step();
    strength = {8'd9, 8'd0, 8'd0, 8'd0};
    #1 expect_out("R1", 3, 0, 0, BASE);
    step();
    strength = {8'd50, 8'd30, 8'd50, 8'd10};
    #1 expect_out("R1", 1, 0, 0, BASE);

    // R2 / R4: trial starts, a fall equal to the threshold is not enough
    violation = 1'b1;
    step();
    expect_out("R2", 3, 0, 0, BASE);
    set_sens(20, 20, 20, 20);
    step();
    expect_out("R4", 3, 0, 0, BASE);
    set_sens(19, 20, 20, 20);
    step();
    violation = 1'b0;
    set_sens(25, 25, 25, 25);
    #1 expect_out("R4", 1, 1, 3, BASE);
    step();
    expect_out("R10", 1, 0, 0, BASE);

    // R3: the violation clears during the trial
    violation = 1'b1;
    step();
    expect_out("R2", 3, 0, 0, BASE);
    violation = 1'b0;
    step();
    expect_out("R3", 1, 1, 3, BASE);
    step();
    expect_out("R10", 1, 0, 0, BASE);

    // R5 / R6: a rise equal to the threshold is ignored, then a timeout, then a real rise
    violation = 1'b1;
    step();
    expect_out("R2", 3, 0, 0, BASE);
    set_sens(30, 30, 30, 30);
    step();
    expect_out("R5", 3, 0, 0, BASE);
    step();
    expect_out("R6", 2, 0, 0, BASE);
    set_sens(30, 30, 30, 60);
    step();
    expect_out("R5", 0, 0, 0, BASE);
    step();
    expect_out("R6", 0, 0, 0, BASE);
    step();
    expect_out("R7", 1, 0, 0, 2 * BASE);

    // R7: each full pass doubles the period up to the ceiling
    d = 2 * BASE;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 4; i++) begin
        int nd;
        for (int k = 1; k < d; k++) begin
          step();
          expect_out("R6", order[i], 0, 0, d);
        end
        nd = (i == 3) ? ((2 * d > MAXL) ? MAXL : 2 * d) : d;
        step();
        expect_out("R7", order[(i + 1) % 4], 0, 0, nd);
        d = nd;
      end
    end

    // R8: success brings the period back to the base value
    violation = 1'b0;
    step();
    expect_out("R8", 1, 1, 1, BASE);
    step();
    expect_out("R10", 1, 0, 0, BASE);

    step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule